// File: doc/BRIEF.md
# Runtime-Depth Word FIFO with Status Flags

This block is a synchronous word queue for one direction of a serial peripheral. It stores up to 32 words. The number of words it accepts before it reports full is chosen on every cycle from the configured frame width. Narrow frames use the whole store. Wider frames use half of it or a quarter of it.

The block has a push port and a pop port. The word at the head of the queue is always visible on the read data output. A pop takes that word and moves on to the next one. A synchronous flush discards everything in the queue. The block reports these flags:
- empty and almost-empty (exactly one entry left);
- full and one-before-full;
- a sticky overflow flag. It is raised when a push arrives while the queue is full, and a pop clears it.

Serial shifting, bus decoding and interrupt generation belong to the surrounding logic.

Top module: `fifo_rtdepth`

## Requirements
- R1: The active depth is 32 when `frame_size` is 0 to 8, 16 when it is 9 to 16, and 8 for any larger value (17 to 63).
- R2: Words leave in the order they were accepted. `level` gives the number of stored words after each clock edge.
- R3: `full` is high when `level` is greater than or equal to the active depth. `almost_full` is high when `level` equals the active depth minus one.
- R4: A push is dropped when `level` is at or above the active depth. The stored words and `level` do not change.
- R5: A dropped push sets `overflow`. `overflow` stays high until a pop or a flush clears it.
- R6: A pop clears `overflow` on the next edge, unless that same cycle also carries a dropped push.
- R7: `empty` is high when `level` is 0. `almost_empty` is high when `level` is 1.
- R8: While the queue is empty, `pop_data` reads 0, and a pop without a push leaves all state unchanged.
- R9: A flush empties the queue and clears `overflow`. It takes priority over a push or a pop in the same cycle.
- R10: A push and a pop in the same cycle, on a queue that is neither empty nor full, leave `level` unchanged and keep the order.
- R11: After reset, `level` is 0, `empty` is high, and `full` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of the queue |
| frame_size | input | 6 | Configured frame width in bits; selects the active depth |
| push | input | 1 | Write request |
| push_data | input | 32 | Word to store |
| pop | input | 1 | Read request |
| pop_data | output | 32 | Head word, or 0 when empty |
| level | output | 6 | Number of stored words |
| empty | output | 1 | Queue holds no word |
| almost_empty | output | 1 | Queue holds exactly one word |
| almost_full | output | 1 | One word short of the active depth |
| full | output | 1 | Occupancy at or above the active depth |
| overflow | output | 1 | Sticky: a push was dropped |

## Verification
The bench fills the queue to each of the three depths. It then pushes into the full queue: a design that stored the word or advanced `level` would corrupt the head order or exceed the depth. It shrinks the frame width while the queue holds more words than the new depth allows: a design that compared with equality would drop `full` and accept more words. It pops an empty queue, where a wrong design would underflow `level` or show stale data. It also checks a push and a pop on a full queue in the same cycle, a flush together with a push and a pop, and a pop right after an overflow, where a flag that does not stick or does not clear would show.

// File: rtl/fifo_rtdepth.sv
module fifo_rtdepth #(
  parameter int DATA_W     = 32,
  parameter int CAP        = 32,
  parameter int FS_W       = 6,
  parameter int NARROW_MAX = 8,
  parameter int MID_MAX    = 16,
  localparam int PTR_W     = $clog2(CAP),
  localparam int CNT_W     = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [FS_W-1:0]   frame_size,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  level,
  output logic              empty,
  output logic              almost_empty,
  output logic              almost_full,
  output logic              full,
  output logic              overflow
);
  localparam logic [CNT_W-1:0] DEPTH_HI  = CNT_W'(CAP);
  localparam logic [CNT_W-1:0] DEPTH_MID = CNT_W'(CAP / 2);
  localparam logic [CNT_W-1:0] DEPTH_LO  = CNT_W'(CAP / 4);

  logic [DATA_W-1:0] mem [CAP];
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  wr_idx;
  logic [CNT_W-1:0]  depth;
  logic              do_push, do_pop, drop;

  always_comb begin
    if (int'(frame_size) <= NARROW_MAX)   depth = DEPTH_HI;
    else if (int'(frame_size) <= MID_MAX) depth = DEPTH_MID;
    else                                  depth = DEPTH_LO;
  end

  assign empty        = (level == '0);
  assign almost_empty = (level == CNT_W'(1));
  assign full         = (level >= depth);
  assign almost_full  = (level == depth - CNT_W'(1));

  assign do_push  = push && !full && !flush;
  assign drop     = push && full && !flush;
  assign do_pop   = pop && !empty && !flush;
  assign wr_idx   = rd_ptr + level[PTR_W-1:0];
  assign pop_data = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk)
    if (do_push) mem[wr_idx] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      rd_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_pop) rd_ptr <= rd_ptr + PTR_W'(1);
      if (do_push && !do_pop)      level <= level + CNT_W'(1);
      else if (do_pop && !do_push) level <= level - CNT_W'(1);
      if (drop)     overflow <= 1'b1;
      else if (pop) overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_rtdepth_chk.sv
module fifo_rtdepth_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             push,
  input logic             pop,
  input logic [CNT_W-1:0] level,
  input logic             empty,
  input logic             full,
  input logic             overflow
);
  AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !flush |=> $stable(level)); // R4
  AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !flush |=> overflow); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !pop && !flush |=> overflow); // R5
  AST_POP_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !flush && !(push && full) |=> !overflow); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !overflow); // R9
  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push && !flush |=> empty && $stable(overflow)); // R8
  AST_PUSHPOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !empty && !full && !flush |=> $stable(level)); // R10
endmodule

bind fifo_rtdepth fifo_rtdepth_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
  .level(level), .empty(empty), .full(full), .overflow(overflow)
);

// File: tb/sim_fifo_rtdepth.sv
`timescale 1ns/1ps
module sim_fifo_rtdepth;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, push = 1'b0, pop = 1'b0;
  logic [5:0]  frame_size = 6'd4;
  logic [31:0] push_data = '0;
  logic [31:0] pop_data;
  logic [5:0]  level;
  logic empty, almost_empty, almost_full, full, overflow;

  int total = 0, bad = 0;
  bit done = 0;
  int unsigned mq[$];
  bit m_ovf = 0;

  always #5 clk = ~clk;

  fifo_rtdepth u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .frame_size(frame_size),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
    .level(level), .empty(empty), .almost_empty(almost_empty),
    .almost_full(almost_full), .full(full), .overflow(overflow)
  );

  function automatic int depth_of(int fs);
    if (fs <= 8) return 32;
    if (fs <= 16) return 16;
    return 8;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    int d = depth_of(int'(frame_size));
    int n = mq.size();
    check("R2 level", level, n);
    check("R2 head data", pop_data, n > 0 ? mq[0] : 0);
    check("R3 full", full, n >= d);
    check("R3 almost_full", almost_full, n == d - 1);
    check("R7 empty", empty, n == 0);
    check("R7 almost_empty", almost_empty, n == 1);
    check("R5 overflow", overflow, m_ovf);
  endtask

  task automatic cyc(bit p, bit q, bit f, logic [31:0] d);
    int dep;
    bit rej;
    push = p; pop = q; flush = f; push_data = d;
    dep = depth_of(int'(frame_size));
    @(posedge clk);
    if (f) begin
      mq.delete(); m_ovf = 0;
    end else begin
      rej = p && (mq.size() >= dep);
      if (q && mq.size() > 0) void'(mq.pop_front());
      if (p && !rej) mq.push_back(d);
      if (rej) m_ovf = 1;
      else if (q) m_ovf = 0;
    end
    @(negedge clk);
    push = 0; pop = 0; flush = 0;
    compare_all();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    repeat (2) @(negedge clk);
    // R11 reset state
    check("R11 level", level, 0);
    check("R11 empty", empty, 1);
    check("R11 full", full, 0);
    check("R11 overflow", overflow, 0);
    rst_n = 1;
    @(negedge clk);
    // R8 pop on empty
    cyc(0, 1, 0, 0);
    check("R8 empty pop data", pop_data, 0);
    // R1 narrow depth 32
    frame_size = 6'd8;
    for (int i = 0; i < 32; i++) cyc(1, 0, 0, 32'hA000_0000 + i);
    check("R1 depth32 full", full, 1);
    // R4 R5 drop on full
    cyc(1, 0, 0, 32'hDEAD_BEEF);
    check("R4 level kept", level, 32);
    check("R5 ovf set", overflow, 1);
    cyc(0, 0, 0, 0);
    check("R5 ovf sticky", overflow, 1);
    // R6 pop clears overflow
    cyc(0, 1, 0, 0);
    check("R6 ovf cleared", overflow, 0);
    // R3 shrink depth with level above it
    frame_size = 6'd20;
    @(negedge clk);
    compare_all();
    check("R3 full after shrink", full, 1);
    cyc(1, 0, 0, 32'h1);
    check("R4 level after shrink", level, 31);
    // R9 flush wins
    cyc(1, 1, 1, 32'h2);
    check("R9 flush empty", empty, 1);
    // R1 mid depth 16
    frame_size = 6'd9;
    for (int i = 0; i < 16; i++) cyc(1, 0, 0, 32'hB000_0000 + i);
    check("R1 depth16 full", full, 1);
    // push+pop on full queue: push dropped, pop happens
    cyc(1, 1, 0, 32'hC0);
    check("R4 full pushpop level", level, 15);
    cyc(0, 0, 1, 0);
    // R1 wide depth 8 and R10
    frame_size = 6'd63;
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 32'hE000_0000 + i);
    check("R1 depth8 full", full, 1);
    cyc(0, 1, 0, 0);
    cyc(1, 1, 0, 32'hF0);
    check("R10 level stable", level, 7);
    cyc(0, 0, 1, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0) frame_size = 6'($urandom_range(0, 63));
      cyc($urandom_range(0, 99) < 55, $urandom_range(0, 99) < 45,
          $urandom_range(0, 299) == 0, $urandom);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule